// File: doc/BRIEF.md
# Indexed Interrupt Routing Register File

This block is the register file of an interrupt router, reached from a simple single-cycle bus through two locations. One location holds a register index. The other is a data window that reads or writes whichever register that index selects. Software first writes the index, then accesses the window, and repeats this for each register it needs.

The index selects one of three things. Low indices name three identity registers: a writable identifier, a fixed version word and a read-only arbitration word. A band of indices starting at 0x10 names a routing table with one 64-bit entry per interrupt pin, held as a low word and a high word. Every other index is empty.

For each pin, the block drives an interrupt vector and a destination onto parallel outputs for the routing logic. A destination byte of all ones is widened to a 32-bit all-ones value, which means every target. The block does not deliver interrupts, sense pins or build messages.

Top module: `irq_route_regs`

## Requirements
- R1: Only bus offsets 0x00 (index) and 0x10 (data window) are valid. A request to any other offset returns `rsp_err`=1 with `rsp_rdata`=0 and changes no register.
- R2: A write to offset 0x00 stores all 32 bits of write data as the index. A read of offset 0x00 returns the stored index.
- R3: Window index 0 is the identifier. All 32 bits can be read and written through the window.
- R4: Window index 1 always reads 0x00170011, and writes to it have no effect.
- R5: Window index 2 is the arbitration word. It reads 0, and writes to it have no effect.
- R6: With PINS=24, pin n's low word is at index 0x10+2n and its high word at index 0x10+2n+1. Each word reads back all 32 bits as written.
- R7: `pin_vector[8n +: 8]` takes bits [7:0] of a write to pin n's low word only when that field is nonzero. A zero field leaves the output unchanged.
- R8: `pin_dest[32n +: 32]` is bits [31:24] of pin n's high word, zero-extended. When that byte is 0xFF, the output is 0xFFFFFFFF.
- R9: A window read of index 3..0x0F or of any index at or above 0x40 returns 0xFFFFFFFF. A window write to such an index changes no register.
- R10: After reset, the index and identifier are 0. Every low word is 0x00010000 (mask bit 16 set), every high word is 0, and all vector and destination outputs are 0.
- R11: Each accepted request is answered by `rsp_valid`=1 on the next cycle only. A read response carries its data in `rsp_rdata`, and a write response carries 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 8 | Byte offset of the request |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Invalid offset |
| rsp_rdata | output | 32 | Read data |
| pin_vector | output | 192 | Per-pin vector, 8 bits per pin, pin 0 in the low bits |
| pin_dest | output | 768 | Per-pin destination, 32 bits per pin, pin 0 in the low bits |

## Verification
On every cycle, the assertions check four things:
- each request gets exactly one response one cycle later;
- a bad offset raises the error flag and leaves the index untouched;
- an index write lands on the next edge;
- the version read is constant, and a zero-vector write leaves that pin's vector output unchanged.

Some behaviour only the bench scenarios can show:
- the full index-to-register mapping at both ends of the table;
- the broadcast widening;
- out-of-range writes that would alias onto table words if the index were only partly decoded;
- the reset contents of the table.

// File: rtl/irr_pkg.sv
package irr_pkg;
  localparam int          DATA_W      = 32;
  localparam int          VEC_W       = 8;
  localparam int          DEST_LSB    = 24;
  localparam int          MASK_BIT    = 16;
  localparam int          TABLE_BASE  = 16;
  localparam logic [31:0] VERSION_VAL = 32'h0017_0011;
  localparam logic [31:0] EMPTY_VAL   = 32'hFFFF_FFFF;

  typedef enum logic [2:0] {
    SEL_IDENT,
    SEL_VER,
    SEL_ARB,
    SEL_TABLE,
    SEL_NONE
  } win_sel_e;
endpackage

// File: rtl/irr_bus_front.sv
module irr_bus_front
  import irr_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int OFF_IDX = 0,
  parameter int OFF_WIN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] win_rdata,
  output logic [DATA_W-1:0] idx_q,
  output logic              win_we,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic              at_idx, at_win, bad_off;
  logic              idx_en;
  logic [DATA_W-1:0] idx_d;
  logic              rsp_valid_d, rsp_err_d;
  logic [DATA_W-1:0] rsp_rdata_d;

  always_comb begin
    at_idx  = (req_offset == ADDR_W'(OFF_IDX));
    at_win  = (req_offset == ADDR_W'(OFF_WIN));
    bad_off = !(at_idx || at_win);
    idx_en  = req_valid && req_write && at_idx;
    idx_d   = req_wdata;
    win_we  = req_valid && req_write && at_win;
    rsp_valid_d = req_valid;
    rsp_err_d   = req_valid && bad_off;
    rsp_rdata_d = '0;
    if (req_valid && !req_write) begin
      if (at_idx)      rsp_rdata_d = idx_q;
      else if (at_win) rsp_rdata_d = win_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_err   <= rsp_err_d;
      rsp_rdata <= rsp_rdata_d;
    end
  end

  // R1: bad offset flags an error and leaves the index alone
  a_r1_bad_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_offset != ADDR_W'(OFF_IDX) && req_offset != ADDR_W'(OFF_WIN))
      |=> (rsp_err && $stable(idx_q)));

  // R2: index write lands on the next edge
  a_r2_index_load: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_offset == ADDR_W'(OFF_IDX))
      |=> (idx_q == $past(req_wdata)));

  // R11: one response per request, one cycle later
  a_r11_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
endmodule

// File: rtl/irr_decode.sv
module irr_decode
  import irr_pkg::*;
#(
  parameter int PINS  = 24,
  parameter int ENT_W = $clog2(PINS)
) (
  input  logic [DATA_W-1:0] idx,
  output win_sel_e          sel,
  output logic [ENT_W-1:0]  entry,
  output logic              hi_word
);
  localparam logic [DATA_W-1:0] TABLE_LO = DATA_W'(TABLE_BASE);
  localparam logic [DATA_W-1:0] TABLE_HI = DATA_W'(TABLE_BASE + 2 * PINS);

  logic [DATA_W-1:0] rel;

  always_comb begin
    rel     = idx - TABLE_LO;
    entry   = ENT_W'(rel >> 1);
    hi_word = rel[0];
    if (idx == 32'd0)                         sel = SEL_IDENT;
    else if (idx == 32'd1)                    sel = SEL_VER;
    else if (idx == 32'd2)                    sel = SEL_ARB;
    else if (idx >= TABLE_LO && idx < TABLE_HI) sel = SEL_TABLE;
    else                                      sel = SEL_NONE;
  end
endmodule

// File: rtl/irr_redir_table.sv
module irr_redir_table
  import irr_pkg::*;
#(
  parameter int PINS  = 24,
  parameter int ENT_W = $clog2(PINS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [ENT_W-1:0]        entry,
  input  logic                    hi_word,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       rd_word,
  output logic [PINS*VEC_W-1:0]   pin_vector,
  output logic [PINS*DATA_W-1:0]  pin_dest
);
  localparam logic [DATA_W-1:0] LO_RESET = DATA_W'(1) << MASK_BIT;

  logic [PINS-1:0][DATA_W-1:0] lo_q, hi_q;
  logic [PINS-1:0][VEC_W-1:0]  vec_q;
  logic [PINS-1:0]             lo_en, hi_en, vec_en;
  logic                        vec_nz;

  always_comb begin
    vec_nz = (wdata[VEC_W-1:0] != '0);
    for (int p = 0; p < PINS; p++) begin
      lo_en[p]  = we && (entry == ENT_W'(p)) && !hi_word;
      hi_en[p]  = we && (entry == ENT_W'(p)) && hi_word;
      vec_en[p] = lo_en[p] && vec_nz;
    end
    rd_word = hi_word ? hi_q[entry] : lo_q[entry];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < PINS; p++) begin
        lo_q[p]  <= LO_RESET;
        hi_q[p]  <= '0;
        vec_q[p] <= '0;
      end
    end else begin
      for (int p = 0; p < PINS; p++) begin
        if (lo_en[p])  lo_q[p]  <= wdata;
        if (hi_en[p])  hi_q[p]  <= wdata;
        if (vec_en[p]) vec_q[p] <= wdata[VEC_W-1:0];
      end
    end
  end

  for (genvar g = 0; g < PINS; g++) begin : g_pin
    logic [7:0] dbyte;
    assign dbyte = hi_q[g][DEST_LSB +: 8];
    assign pin_vector[g*VEC_W +: VEC_W] = vec_q[g];
    assign pin_dest[g*DATA_W +: DATA_W] =
      (dbyte == 8'hFF) ? EMPTY_VAL : {{(DATA_W-8){1'b0}}, dbyte};

    // R7: a zero vector field leaves the exported vector unchanged
    a_r7_zero_vec_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !hi_word && entry == ENT_W'(g) && wdata[VEC_W-1:0] == '0)
        |=> $stable(pin_vector[g*VEC_W +: VEC_W]));
  end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irr_pkg::*;
#(
  parameter int          PINS    = 24,
  parameter int          ADDR_W  = 8,
  parameter logic [31:0] ARB_ID  = 32'h0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_offset,
  input  logic [31:0]            req_wdata,
  output logic                   rsp_valid,
  output logic                   rsp_err,
  output logic [31:0]            rsp_rdata,
  output logic [PINS*8-1:0]      pin_vector,
  output logic [PINS*32-1:0]     pin_dest
);
  localparam int ENT_W   = $clog2(PINS);
  localparam int OFF_WIN = 16;

  logic [DATA_W-1:0] idx_q, win_rdata, tbl_rd, ident_q;
  logic              win_we, hi_word, ident_en, tbl_we;
  logic [ENT_W-1:0]  entry;
  win_sel_e          sel;

  irr_bus_front #(.ADDR_W(ADDR_W), .OFF_IDX(0), .OFF_WIN(OFF_WIN)) u_front (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_offset(req_offset), .req_wdata(req_wdata),
    .win_rdata(win_rdata), .idx_q(idx_q), .win_we(win_we),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  irr_decode #(.PINS(PINS), .ENT_W(ENT_W)) u_dec (
    .idx(idx_q), .sel(sel), .entry(entry), .hi_word(hi_word)
  );

  irr_redir_table #(.PINS(PINS), .ENT_W(ENT_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .we(tbl_we), .entry(entry), .hi_word(hi_word), .wdata(req_wdata),
    .rd_word(tbl_rd), .pin_vector(pin_vector), .pin_dest(pin_dest)
  );

  always_comb begin
    ident_en = win_we && (sel == SEL_IDENT);
    tbl_we   = win_we && (sel == SEL_TABLE);
    case (sel)
      SEL_IDENT: win_rdata = ident_q;
      SEL_VER:   win_rdata = VERSION_VAL;
      SEL_ARB:   win_rdata = ARB_ID;
      SEL_TABLE: win_rdata = tbl_rd;
      default:   win_rdata = EMPTY_VAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ident_q <= '0;
    end else if (ident_en) begin
      ident_q <= req_wdata;
    end
  end

  // R4: a window read of the version index always answers the constant
  a_r4_version_const: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_offset == ADDR_W'(OFF_WIN) && sel == SEL_VER)
      |=> (rsp_rdata == VERSION_VAL));

  // R9: a write to an empty index leaves the identifier alone
  a_r9_empty_write_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (win_we && sel == SEL_NONE) |=> $stable(ident_q));
endmodule

// File: tb/test_irq_route_regs.sv
`timescale 1ns/1ps
module test_irq_route_regs;
  localparam int PINS = 24;

  logic              clk;
  logic              rst_n;
  logic              req_valid, req_write;
  logic [7:0]        req_offset;
  logic [31:0]       req_wdata;
  logic              rsp_valid, rsp_err;
  logic [31:0]       rsp_rdata;
  logic [PINS*8-1:0] pin_vector;
  logic [PINS*32-1:0] pin_dest;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  irq_route_regs i_irq_route_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_offset(req_offset), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .pin_vector(pin_vector), .pin_dest(pin_dest)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // one request; response sampled at the following negedge
  task automatic bus(input bit wr, input logic [7:0] off, input logic [31:0] wd,
                     output logic [31:0] rd, output logic er);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_offset = off; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_offset = 8'h0; req_wdata = '0;
    rd = rsp_rdata; er = rsp_err;
    chk(rsp_valid === 1'b1, "R11 rsp_valid", {31'b0, rsp_valid}, 32'h1);
  endtask

  task automatic wr_reg(input logic [31:0] idx, input logic [31:0] v);
    logic [31:0] d; logic e;
    bus(1'b1, 8'h00, idx, d, e);
    bus(1'b1, 8'h10, v, d, e);
  endtask

  task automatic rd_reg(input logic [31:0] idx, output logic [31:0] v);
    logic [31:0] d; logic e;
    bus(1'b1, 8'h00, idx, d, e);
    bus(1'b0, 8'h10, 32'h0, v, e);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk(pin_vector == '0, "R10 vectors zero", pin_vector[31:0], 32'h0);
    chk(pin_dest == '0, "R10 dests zero", pin_dest[31:0], 32'h0);
    begin logic e; bus(1'b0, 8'h00, 32'h0, v, e); end
    chk(v == 32'h0, "R10 index reset", v, 32'h0);
    rd_reg(32'h0, v);  chk(v == 32'h0, "R10 ident reset", v, 32'h0);
    rd_reg(32'h10, v); chk(v == 32'h0001_0000, "R10 pin0 low reset", v, 32'h0001_0000);
    rd_reg(32'h3F, v); chk(v == 32'h0, "R10 pin23 high reset", v, 32'h0);
  endtask

  task automatic t_index;
    logic [31:0] v; logic e;
    bus(1'b1, 8'h00, 32'hDEAD_BEEF, v, e);
    chk(v == 32'h0, "R11 write rdata zero", v, 32'h0);
    bus(1'b0, 8'h00, 32'h0, v, e);
    chk(v == 32'hDEAD_BEEF, "R2 index readback", v, 32'hDEAD_BEEF);
  endtask

  task automatic t_ident;
    logic [31:0] v;
    wr_reg(32'h0, 32'hA5C3_0F12);
    rd_reg(32'h0, v);
    chk(v == 32'hA5C3_0F12, "R3 ident readback", v, 32'hA5C3_0F12);
  endtask

  task automatic t_fixed;
    logic [31:0] v;
    wr_reg(32'h1, 32'h1234_5678);
    rd_reg(32'h1, v);
    chk(v == 32'h0017_0011, "R4 version", v, 32'h0017_0011);
    wr_reg(32'h2, 32'h0F00_0000);
    rd_reg(32'h2, v);
    chk(v == 32'h0, "R5 arbitration", v, 32'h0);
  endtask

  task automatic t_table;
    logic [31:0] v;
    wr_reg(32'h10 + 2*7, 32'h1357_9BDF);
    wr_reg(32'h10 + 2*7 + 1, 32'h0246_8ACE);
    rd_reg(32'h10 + 2*7, v);
    chk(v == 32'h1357_9BDF, "R6 pin7 low", v, 32'h1357_9BDF);
    rd_reg(32'h10 + 2*7 + 1, v);
    chk(v == 32'h0246_8ACE, "R6 pin7 high", v, 32'h0246_8ACE);
    rd_reg(32'h10 + 2*8, v);
    chk(v == 32'h0001_0000, "R6 pin8 untouched", v, 32'h0001_0000);
  endtask

  task automatic t_vector;
    wr_reg(32'h10 + 2*3, 32'h0001_0042);
    chk(pin_vector[3*8 +: 8] == 8'h42, "R7 pin3 vector", {24'b0, pin_vector[3*8 +: 8]}, 32'h42);
    wr_reg(32'h10 + 2*3, 32'h0000_0000);
    chk(pin_vector[3*8 +: 8] == 8'h42, "R7 zero keeps", {24'b0, pin_vector[3*8 +: 8]}, 32'h42);
    wr_reg(32'h10 + 2*23, 32'h0000_0055);
    chk(pin_vector[23*8 +: 8] == 8'h55, "R7 pin23 vector", {24'b0, pin_vector[23*8 +: 8]}, 32'h55);
  endtask

  task automatic t_dest;
    wr_reg(32'h10 + 2*5 + 1, 32'h1200_00FF);
    chk(pin_dest[5*32 +: 32] == 32'h12, "R8 pin5 dest", pin_dest[5*32 +: 32], 32'h12);
    wr_reg(32'h10 + 2*5 + 1, 32'hFF00_0000);
    chk(pin_dest[5*32 +: 32] == 32'hFFFF_FFFF, "R8 broadcast", pin_dest[5*32 +: 32], 32'hFFFF_FFFF);
    wr_reg(32'h3F, 32'hFE00_0000);
    chk(pin_dest[23*32 +: 32] == 32'hFE, "R8 pin23 dest", pin_dest[23*32 +: 32], 32'hFE);
  endtask

  task automatic t_empty;
    logic [31:0] v;
    wr_reg(32'h0, 32'h0000_ABCD);
    wr_reg(32'h50, 32'h0000_1234);
    rd_reg(32'h50, v);
    chk(v == 32'hFFFF_FFFF, "R9 high index read", v, 32'hFFFF_FFFF);
    wr_reg(32'h40, 32'h0000_0099);
    wr_reg(32'h05, 32'h0000_0077);
    rd_reg(32'h05, v);
    chk(v == 32'hFFFF_FFFF, "R9 gap index read", v, 32'hFFFF_FFFF);
    rd_reg(32'h0, v);
    chk(v == 32'h0000_ABCD, "R9 ident kept", v, 32'h0000_ABCD);
    rd_reg(32'h10, v);
    chk(v == 32'h0001_0000, "R9 pin0 low kept", v, 32'h0001_0000);
    chk(pin_vector[7:0] == 8'h0, "R9 pin0 vector kept", {24'b0, pin_vector[7:0]}, 32'h0);
  endtask

  task automatic t_bad_offset;
    logic [31:0] v; logic e;
    bus(1'b1, 8'h00, 32'h0000_0011, v, e);
    bus(1'b1, 8'h08, 32'h0000_0077, v, e);
    chk(e === 1'b1, "R1 error flag", {31'b0, e}, 32'h1);
    bus(1'b0, 8'h14, 32'h0, v, e);
    chk(e === 1'b1 && v == 32'h0, "R1 read error data", v, 32'h0);
    bus(1'b0, 8'h00, 32'h0, v, e);
    chk(v == 32'h11 && e === 1'b0, "R1 index unchanged", v, 32'h11);
  endtask

  task automatic t_timing;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R11 idle no response", {31'b0, rsp_valid}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_offset = 8'h0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_index();
    t_ident();
    t_fixed();
    t_table();
    t_vector();
    t_dest();
    t_empty();
    t_bad_offset();
    t_timing();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule